// File: doc/BRIEF.md
# Polled Character Display Output Port

This block connects a 16-bit memory-mapped processor bus to a character display. Software polls a status word to learn whether the display can take another character. When it can, software stores the character into a data word. The port keeps the low byte of that store and presents it to a display-side sink with a valid signal. It holds both the valid signal and the character until the sink returns a one-cycle done pulse. The port then reports itself ready again.

Exactly one character can be in flight. A store to the data word that arrives while a character is still in flight is dropped by the hardware, so software that skips the poll cannot corrupt a pending character. The status word also holds a software-writable interrupt-enable flag. An interrupt request output is raised while the port is ready and that flag is set.

The controller has two states: `ST_READY` and `ST_SENDING`. The transition ACCEPT goes from `ST_READY` to `ST_SENDING` on a data-word store. The transition FINISH goes from `ST_SENDING` to `ST_READY` on a done pulse. A done pulse in `ST_READY`, or a data store in `ST_SENDING`, leaves the state unchanged.

Top module: `dsp_out_port`

## Requirements
- R1: After reset, the port is in `ST_READY`, `out_valid` is 0 and `irq` is 0. A read of the status address (0xFE04) returns 0x8000.
- R2: A store to the data address (0xFE06) in `ST_READY` takes effect at the next clock edge. After that edge, `out_valid` is 1, `out_char` equals the stored bits [7:0], and status bit 15 reads 0.
- R3: A store to the data address in `ST_SENDING` is dropped. `out_char` and the data read-back keep their previous value.
- R4: A `sink_done` pulse in `ST_SENDING` returns the port to `ST_READY` at the next edge. After that edge, `out_valid` is 0 and status bit 15 reads 1. This also holds when a data store arrives in the same cycle; that store is dropped.
- R5: A `sink_done` pulse in `ST_READY` has no effect. The port stays ready and `out_valid` stays 0.
- R6: A store to the status address copies bit 14 of the written word into the interrupt-enable flag. Status bit 15 is not writable. Status bits [13:0] always read 0.
- R7: `irq` is 1 exactly when status bit 15 and status bit 14 are both 1.
- R8: A read of the data address returns the last accepted character in bits [7:0], with bits [15:8] read as 0.
- R9: Reads of any other address return 0. Stores to any other address change nothing.
- R10: While `out_valid` is 1 and no done pulse has arrived, `out_valid` stays 1 and `out_char` stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Bus word address |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_wdata | input | 16 | Bus write data |
| bus_rdata | output | 16 | Bus read data (combinational) |
| out_valid | output | 1 | Character presented to the sink |
| out_char | output | 8 | Character code for the sink |
| sink_done | input | 1 | One-cycle pulse from the sink when the character is consumed |
| irq | output | 1 | Interrupt request |

## Verification
The main function is driven with every one of the 256 character codes. This shows that the full low byte passes through, and that the upper byte of the stored word never leaks into the sink or into the read-back. Each character is followed by a store of its complement while the port is busy; a port that accepted that store would show the wrong character. The done pulse then arrives alone, and in a second pattern together with a new store; this separates a port that reopens correctly from one that latches the colliding store. The interrupt flag is swept against both states, and several unmapped addresses are tried, to tell apart the correct request logic and decode from logic that leaks.

// File: rtl/dsp_pkg.sv
package dsp_pkg;
    typedef enum logic [0:0] {
        ST_READY   = 1'b0,
        ST_SENDING = 1'b1
    } port_state_t;
endpackage

// File: rtl/dsp_decode.sv
module dsp_decode #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter int          CHAR_W    = 8,
    parameter int          READY_BIT = 15,
    parameter int          IE_BIT    = 14,
    parameter logic [15:0] STAT_ADDR = 16'hFE04,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic              ready,
    input  logic              ie,
    input  logic [CHAR_W-1:0] char_q,
    output logic              stat_wr,
    output logic              data_wr,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
    localparam logic [ADDR_W-1:0] DATA_A = ADDR_W'(DATA_ADDR);

    logic hit_stat;
    logic hit_data;

    assign hit_stat = (bus_addr == STAT_A);
    assign hit_data = (bus_addr == DATA_A);
    assign stat_wr  = bus_wr && hit_stat;
    assign data_wr  = bus_wr && hit_data;

    always_comb begin
        rdata = '0;
        if (bus_rd && hit_stat) begin
            rdata[READY_BIT] = ready;
            rdata[IE_BIT]    = ie;
        end else if (bus_rd && hit_data) begin
            rdata[CHAR_W-1:0] = char_q;
        end
    end

    // R9: only one of the two registers can be selected at a time
    always_comb begin
        assert_one_hit_R9: assert (!(hit_stat && hit_data));
    end
endmodule

// File: rtl/dsp_fsm.sv
module dsp_fsm
    import dsp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic data_wr,
    input  logic sink_done,
    output logic ready,
    output logic load,
    output logic out_valid
);
    port_state_t state_q;
    port_state_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_READY;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:   if (data_wr)   state_d = ST_SENDING; // ACCEPT
            ST_SENDING: if (sink_done) state_d = ST_READY;   // FINISH
            default:                   state_d = ST_READY;
        endcase
    end

    always_comb begin
        ready     = 1'b0;
        load      = 1'b0;
        out_valid = 1'b0;
        unique case (state_q)
            ST_READY: begin
                ready = 1'b1;
                load  = data_wr;
            end
            ST_SENDING: out_valid = 1'b1;
            default: ;
        endcase
    end

    assert_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && data_wr) |=> out_valid);
    assert_finish_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && sink_done) |=> (ready && !out_valid));
    assert_idle_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !data_wr) |=> ready);
    assert_hold_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sink_done) |=> out_valid);
endmodule

// File: rtl/dsp_regs.sv
module dsp_regs #(
    parameter int CHAR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              stat_wr,
    input  logic [CHAR_W-1:0] wchar,
    input  logic              wie,
    output logic [CHAR_W-1:0] char_q,
    output logic              ie_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    char_q <= '0;
        else if (load) char_q <= wchar;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       ie_q <= 1'b0;
        else if (stat_wr) ie_q <= wie;
    end

    assert_ie_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stat_wr |=> (ie_q == $past(wie)));
endmodule

// File: rtl/dsp_out_port.sv
module dsp_out_port #(
    parameter int          ADDR_W    = 16,
    parameter int          DATA_W    = 16,
    parameter int          CHAR_W    = 8,
    parameter int          READY_BIT = 15,
    parameter int          IE_BIT    = 14,
    parameter logic [15:0] STAT_ADDR = 16'hFE04,
    parameter logic [15:0] DATA_ADDR = 16'hFE06
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              out_valid,
    output logic [CHAR_W-1:0] out_char,
    input  logic              sink_done,
    output logic              irq
);
    logic              ready;
    logic              load;
    logic              stat_wr;
    logic              data_wr;
    logic              ie_q;
    logic [CHAR_W-1:0] char_q;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    dsp_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CHAR_W(CHAR_W),
        .READY_BIT(READY_BIT), .IE_BIT(IE_BIT),
        .STAT_ADDR(STAT_ADDR), .DATA_ADDR(DATA_ADDR)
    ) u_decode (
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .ready(ready), .ie(ie_q), .char_q(char_q),
        .stat_wr(stat_wr), .data_wr(data_wr), .rdata(bus_rdata)
    );

    dsp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .data_wr(data_wr), .sink_done(sink_done),
        .ready(ready), .load(load), .out_valid(out_valid)
    );

    dsp_regs #(.CHAR_W(CHAR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .load(load), .stat_wr(stat_wr),
        .wchar(bus_wdata[CHAR_W-1:0]), .wie(bus_wdata[IE_BIT]),
        .char_q(char_q), .ie_q(ie_q)
    );

    assign out_char = char_q;
    assign irq      = ready && ie_q;

    assert_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && data_wr) |=> $stable(out_char));
    assert_no_irq_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> !out_valid);
    assert_char_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !sink_done) |=> $stable(out_char));
endmodule

// File: tb/sim_dsp_out_port.sv
module sim_dsp_out_port;
    localparam int          PERIOD = 10;
    localparam logic [15:0] A_STAT = 16'hFE04;
    localparam logic [15:0] A_DATA = 16'hFE06;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        out_valid;
    logic [7:0]  out_char;
    logic        sink_done = 1'b0;
    logic        irq;

    int total = 0;
    int bad   = 0;

    always #(PERIOD/2) clk = ~clk;

    dsp_out_port u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .out_valid(out_valid), .out_char(out_char), .sink_done(sink_done),
        .irq(irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [15:0] d, input logic done);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1; sink_done = done;
        @(posedge clk); #1;
        bus_wr = 1'b0; sink_done = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, output logic [15:0] d);
        bus_addr = a; bus_rd = 1'b1; #1;
        d = bus_rdata; bus_rd = 1'b0; #1;
    endtask

    task automatic done_pulse();
        sink_done = 1'b1;
        @(posedge clk); #1;
        sink_done = 1'b0;
    endtask

    initial begin
        #(PERIOD * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] r;
        logic [7:0]  prev;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        rd(A_STAT, r); chk("R1 status", r, 16'h8000);
        chk("R1 valid", {15'd0, out_valid}, 16'd0);
        chk("R1 irq", {15'd0, irq}, 16'd0);
        // R5 done while ready ignored
        done_pulse();
        chk("R5 valid", {15'd0, out_valid}, 16'd0);
        rd(A_STAT, r); chk("R5 status", r, 16'h8000);

        // sweep all characters
        prev = 8'h00;
        for (int c = 0; c < 256; c++) begin
            logic [7:0] ch;
            ch = 8'(c);
            wr(A_DATA, {~ch, ch}, 1'b0);
            chk("R2 valid", {15'd0, out_valid}, 16'd1);
            chk("R2 char", {8'd0, out_char}, {8'd0, ch});
            rd(A_STAT, r); chk("R2 status", r, 16'h0000);
            rd(A_DATA, r); chk("R8 readback", r, {8'h00, ch});
            // R3 dropped write while busy
            wr(A_DATA, {ch, ~ch}, 1'b0);
            chk("R3 char", {8'd0, out_char}, {8'd0, ch});
            rd(A_DATA, r); chk("R3 readback", r, {8'h00, ch});
            // R10 hold without done
            @(posedge clk); #1;
            chk("R10 valid", {15'd0, out_valid}, 16'd1);
            chk("R10 char", {8'd0, out_char}, {8'd0, ch});
            if (c[0]) begin
                // R4 done colliding with a store: store dropped
                wr(A_DATA, 16'h00A5 ^ {8'd0, ch}, 1'b1);
            end else begin
                done_pulse();
            end
            chk("R4 valid", {15'd0, out_valid}, 16'd0);
            rd(A_STAT, r); chk("R4 status", r, 16'h8000);
            rd(A_DATA, r); chk("R4 readback", r, {8'h00, ch});
            prev = ch;
        end

        // R6/R7 interrupt enable against both states
        for (int e = 0; e < 2; e++) begin
            wr(A_STAT, e[0] ? 16'h7FFF : 16'hBFFF, 1'b0);
            rd(A_STAT, r); chk("R6 ready", r, e[0] ? 16'hC000 : 16'h8000);
            chk("R7 irq ready", {15'd0, irq}, {15'd0, e[0]});
            wr(A_DATA, 16'h0041, 1'b0);
            chk("R7 irq busy", {15'd0, irq}, 16'd0);
            wr(A_STAT, e[0] ? 16'hC000 : 16'h8000, 1'b0);
            rd(A_STAT, r); chk("R6 busy bit15 ro", r, e[0] ? 16'h4000 : 16'h0000);
            done_pulse();
            chk("R7 irq after done", {15'd0, irq}, {15'd0, e[0]});
        end
        wr(A_STAT, 16'h0000, 1'b0);
        chk("R6 ie cleared", {15'd0, irq}, 16'd0);

        // R9 unmapped addresses
        for (int k = 0; k < 6; k++) begin
            logic [15:0] a;
            a = (k == 0) ? 16'hFE00 : (k == 1) ? 16'hFE02 : (k == 2) ? 16'hFE05 :
                (k == 3) ? 16'hFE07 : (k == 4) ? 16'h7E06 : 16'h0000;
            wr(a, 16'hFFFF, 1'b0);
            chk("R9 no accept", {15'd0, out_valid}, 16'd0);
            rd(a, r); chk("R9 read zero", r, 16'h0000);
            rd(A_STAT, r); chk("R9 status", r, 16'h8000);
            rd(A_DATA, r); chk("R9 data", r, 16'h0041);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule